// File: doc/BRIEF.md
# Multi-Source Reset Sequencer

This block generates the chip-wide internal reset. Three requesters can start a reset sequence: the external reset pin, a digital low-voltage comparator output and a watchdog expiry pulse. Every sequence goes through four phases in a fixed order: a reset-active phase, a long stabilisation delay so the oscillator can settle, a short vector-fetch phase, and the run phase. The core is held in reset through the first two phases. The fetch phase is signalled on its own output so the core can load its start address. Code runs only in the run phase.

The length of the reset-active phase depends on the source, and the watchdog has the shortest. A supply-drop reset cannot leave the reset-active phase until the supply indication is above the upper (rising) threshold. The lower falling threshold is what starts such a reset, and the gap between the two thresholds is the hysteresis. When the reset comes from inside the chip, the block pulls the open-drain reset pin low so that other devices on the board are also reset. The pin input passes through a synchroniser and a minimum-width filter. The block ignores the pin while it drives the pin itself, and for the synchroniser latency after it lets the pin go. A sticky cause register reports the source of the most recent reset and clears on a read strobe.

Top module: `rstseq_top`

## Requirements
- R1: While `arst_n` is low and after it is released, `seq_phase` is 0 (reset-active), `core_rst_n` is 0, `pin_drv_low` is 0 and `rst_cause` is 00 (power-up). The power-up sequence then runs with the long active length and no supply wait.
- R2: Phase codes are 0 active, 1 delay, 2 fetch, 3 run. In the run phase, a watchdog pulse or a high `lvd_below_fall` enters phase 0 on the next clock. An external pin held low for at least MIN_PULSE consecutive clocks enters phase 0 SYNC_STAGES+MIN_PULSE clocks after the first low clock, which is 6 at the defaults.
- R3: A low pin pulse shorter than MIN_PULSE clocks is ignored. The phase stays at run and `rst_cause` does not change.
- R4: The reset-active phase lasts ACT_LONG clocks (16) for external, supply and power-up resets, and ACT_SHORT clocks (8) for watchdog resets, provided the supply is good.
- R5: The delay phase lasts exactly DELAY_CYC clocks (4096), with `core_rst_n` low.
- R6: The fetch phase lasts exactly 2 clocks. During it `vec_fetch` is 1 and `core_rst_n` is 1. The run phase follows.
- R7: `pin_drv_low` is 1 throughout the active and delay phases of supply and watchdog resets only. It is never 1 for external or power-up resets. The block's own pin drive never qualifies as an external request.
- R8: The active phase is never left while `lvd_above_rise` is 0. If the supply recovers after the active length has elapsed, the delay phase starts on the clock after `lvd_above_rise` rises.
- R9: A request during the delay or fetch phase restarts the sequence at phase 0 on the same timing as from run, and it updates `rst_cause`.
- R10: Requests that arrive during the reset-active phase are ignored. The cause and the timing stay as they were.
- R11: Cause codes are 01 external, 10 supply, 11 watchdog. When requests arrive together, the supply request wins over the watchdog, and the watchdog wins over the pin.
- R12: `rst_cause` holds its value through run. A one-clock `cause_rd_clr` sets it to 00 on the next clock, unless a request starts a sequence in the same clock, in which case the new cause is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| arst_n | input | 1 | Asynchronous power-on reset, active low |
| rst_pin_n | input | 1 | Raw level of the reset pin, active low |
| lvd_below_fall | input | 1 | Supply is below the falling threshold |
| lvd_above_rise | input | 1 | Supply is above the rising threshold |
| wdg_expire | input | 1 | One-clock watchdog timeout pulse |
| cause_rd_clr | input | 1 | Read-to-clear strobe for the cause register |
| core_rst_n | output | 1 | Internal reset to the core, active low |
| vec_fetch | output | 1 | High during the vector-fetch phase |
| seq_phase | output | 2 | Current phase code |
| pin_drv_low | output | 1 | Open-drain enable that pulls the reset pin low |
| rst_cause | output | 2 | Sticky cause of the most recent reset |

## Verification
The checker assumes that the two comparator flags never claim both states at once, except for an out-of-sequence glitch in the active phase that the block must ignore. It also assumes that the watchdog input is a single-clock pulse and that the reset pin is the wired-AND of the external driver and `pin_drv_low`. The bench models the pin as that wired-AND, so the block's own drive really reaches the pin input. It changes the supply flags only in matched pairs, drops the falling flag before it raises the rising flag, and drives each request one clock after an edge. This keeps every phase change on a clock count it can predict.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

  typedef enum logic [1:0] {
    PH_ACTIVE = 2'd0,
    PH_DELAY  = 2'd1,
    PH_FETCH  = 2'd2,
    PH_RUN    = 2'd3
  } phase_t;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_EXT  = 2'd1,
    SRC_LVD  = 2'd2,
    SRC_WDG  = 2'd3
  } src_t;

  // Fixed arbitration: supply first, then watchdog, then pin.
  function automatic src_t pick_source(input logic lvd, input logic wdg, input logic ext);
    if (lvd)      return SRC_LVD;
    else if (wdg) return SRC_WDG;
    else if (ext) return SRC_EXT;
    else          return SRC_NONE;
  endfunction

  function automatic logic is_internal(input src_t s);
    return (s == SRC_LVD) || (s == SRC_WDG);
  endfunction

  function automatic phase_t next_phase(input phase_t p);
    case (p)
      PH_ACTIVE: return PH_DELAY;
      PH_DELAY:  return PH_FETCH;
      default:   return PH_RUN;
    endcase
  endfunction

  function automatic logic holds_core(input phase_t p);
    return (p == PH_ACTIVE) || (p == PH_DELAY);
  endfunction

endpackage

// File: rtl/rstseq_sync.sv
module rstseq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh <= '1;
    else         sh <= {sh[STAGES-2:0], d};
  end

  assign q = sh[STAGES-1];
endmodule

// File: rtl/rstseq_pinqual.sv
module rstseq_pinqual #(
  parameter int MIN_PULSE = 4
) (
  input  logic clk,
  input  logic arst_n,
  input  logic pin_s_n,
  input  logic mask,
  output logic fire
);
  localparam int QW = $clog2(MIN_PULSE + 1);
  localparam logic [QW-1:0] FIRE_AT = QW'(MIN_PULSE - 1);
  localparam logic [QW-1:0] SAT     = QW'(MIN_PULSE);

  logic [QW-1:0] low_cnt;

  // One event per low stretch: the count saturates past the firing value.
  assign fire = !mask && !pin_s_n && (low_cnt == FIRE_AT);

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)                low_cnt <= '0;
    else if (mask || pin_s_n)   low_cnt <= '0;
    else if (low_cnt != SAT)    low_cnt <= low_cnt + 1'b1;
  end
endmodule

// File: rtl/rstseq_fsm.sv
module rstseq_fsm
  import rstseq_pkg::*;
#(
  parameter int ACT_LONG  = 16,
  parameter int ACT_SHORT = 8,
  parameter int DELAY_CYC = 4096,
  parameter int FETCH_CYC = 2
) (
  input  logic   clk,
  input  logic   arst_n,
  input  logic   req_ext,
  input  logic   req_lvd,
  input  logic   req_wdg,
  input  logic   supply_ok,
  input  logic   status_clr,
  output phase_t phase,
  output src_t   src,
  output src_t   cause,
  output logic   seq_start,
  output logic   phase_done
);
  localparam int MAXA   = (ACT_LONG > ACT_SHORT) ? ACT_LONG : ACT_SHORT;
  localparam int MAXB   = (DELAY_CYC > FETCH_CYC) ? DELAY_CYC : FETCH_CYC;
  localparam int MAXLEN = (MAXA > MAXB) ? MAXA : MAXB;
  localparam int CW     = $clog2(MAXLEN + 1);

  localparam logic [CW-1:0] LAST_LONG  = CW'(ACT_LONG - 1);
  localparam logic [CW-1:0] LAST_SHORT = CW'(ACT_SHORT - 1);
  localparam logic [CW-1:0] LAST_DELAY = CW'(DELAY_CYC - 1);
  localparam logic [CW-1:0] LAST_FETCH = CW'(FETCH_CYC - 1);

  logic [CW-1:0] cnt;
  src_t          win;
  logic          any_req;
  logic          at_last;

  function automatic logic [CW-1:0] last_of(input phase_t p, input src_t s);
    case (p)
      PH_ACTIVE: return (s == SRC_WDG) ? LAST_SHORT : LAST_LONG;
      PH_DELAY:  return LAST_DELAY;
      PH_FETCH:  return LAST_FETCH;
      default:   return '0;
    endcase
  endfunction

  assign win        = pick_source(req_lvd, req_wdg, req_ext);
  assign any_req    = req_ext || req_lvd || req_wdg;
  assign seq_start  = any_req && (phase != PH_ACTIVE);
  assign at_last    = (cnt == last_of(phase, src));
  assign phase_done = at_last && (phase != PH_RUN) &&
                      ((phase != PH_ACTIVE) || supply_ok);

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      phase <= PH_ACTIVE;
      src   <= SRC_NONE;
      cnt   <= '0;
    end else if (seq_start) begin
      phase <= PH_ACTIVE;
      src   <= win;
      cnt   <= '0;
    end else if (phase_done) begin
      phase <= next_phase(phase);
      cnt   <= '0;
    end else if (!at_last) begin
      cnt   <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)         cause <= SRC_NONE;
    else if (seq_start)  cause <= win;
    else if (status_clr) cause <= SRC_NONE;
  end
endmodule

// File: rtl/rstseq_top.sv
module rstseq_top
  import rstseq_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int MIN_PULSE   = 4,
  parameter int ACT_LONG    = 16,
  parameter int ACT_SHORT   = 8,
  parameter int DELAY_CYC   = 4096,
  parameter int FETCH_CYC   = 2
) (
  input  logic       clk,
  input  logic       arst_n,
  input  logic       rst_pin_n,
  input  logic       lvd_below_fall,
  input  logic       lvd_above_rise,
  input  logic       wdg_expire,
  input  logic       cause_rd_clr,
  output logic       core_rst_n,
  output logic       vec_fetch,
  output logic [1:0] seq_phase,
  output logic       pin_drv_low,
  output logic [1:0] rst_cause
);
  phase_t phase_w;
  src_t   seq_src;
  src_t   cause_w;
  logic   pin_s_n;
  logic   pin_mask;
  logic   ext_fire;
  logic   seq_start;
  logic   phase_done;
  logic [SYNC_STAGES-1:0] drv_hist;

  rstseq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .arst_n(arst_n), .d(rst_pin_n), .q(pin_s_n)
  );

  // Own drive is still visible through the synchroniser after release.
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) drv_hist <= '0;
    else         drv_hist <= {drv_hist[SYNC_STAGES-2:0], pin_drv_low};
  end
  assign pin_mask = pin_drv_low || (|drv_hist);

  rstseq_pinqual #(.MIN_PULSE(MIN_PULSE)) u_qual (
    .clk(clk), .arst_n(arst_n), .pin_s_n(pin_s_n), .mask(pin_mask), .fire(ext_fire)
  );

  rstseq_fsm #(
    .ACT_LONG(ACT_LONG), .ACT_SHORT(ACT_SHORT),
    .DELAY_CYC(DELAY_CYC), .FETCH_CYC(FETCH_CYC)
  ) u_fsm (
    .clk(clk), .arst_n(arst_n),
    .req_ext(ext_fire), .req_lvd(lvd_below_fall), .req_wdg(wdg_expire),
    .supply_ok(lvd_above_rise), .status_clr(cause_rd_clr),
    .phase(phase_w), .src(seq_src), .cause(cause_w),
    .seq_start(seq_start), .phase_done(phase_done)
  );

  assign seq_phase   = phase_w;
  assign core_rst_n  = !holds_core(phase_w);
  assign vec_fetch   = (phase_w == PH_FETCH);
  assign pin_drv_low = holds_core(phase_w) && is_internal(seq_src);
  assign rst_cause   = cause_w;
endmodule

// File: rtl/rstseq_chk.sv
module rstseq_chk
  import rstseq_pkg::*;
#(
  parameter int DELAY_CYC = 4096
) (
  input logic       clk,
  input logic       arst_n,
  input logic [1:0] seq_phase,
  input logic       core_rst_n,
  input logic       vec_fetch,
  input logic       pin_drv_low,
  input logic [1:0] rst_cause,
  input logic       lvd_above_rise,
  input logic       cause_rd_clr,
  input logic       seq_start,
  input logic       phase_done
);
  int dly_cnt;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)                    dly_cnt <= 0;
    else if (seq_phase == PH_DELAY) dly_cnt <= dly_cnt + 1;
    else                            dly_cnt <= 0;
  end

  // R5
  delay_len_chk: assert property (@(posedge clk) disable iff (!arst_n)
    (seq_phase == PH_FETCH && $past(seq_phase) == PH_DELAY) |-> dly_cnt == DELAY_CYC);

  // R6
  fetch_hold_chk: assert property (@(posedge clk) disable iff (!arst_n)
    ($rose(vec_fetch) && !seq_start) |=> vec_fetch && core_rst_n);

  // R6
  fetch_end_chk: assert property (@(posedge clk) disable iff (!arst_n)
    (vec_fetch && $past(vec_fetch)) |=> !vec_fetch);

  // R7
  pin_launch_chk: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(pin_drv_low) |-> $past(seq_start));

  // R7
  pin_in_reset_chk: assert property (@(posedge clk) disable iff (!arst_n)
    pin_drv_low |-> !core_rst_n);

  // R8
  supply_gate_chk: assert property (@(posedge clk) disable iff (!arst_n)
    (seq_phase == PH_ACTIVE && !lvd_above_rise && !seq_start) |=> seq_phase == PH_ACTIVE);

  // R9
  restart_chk: assert property (@(posedge clk) disable iff (!arst_n)
    seq_start |=> seq_phase == PH_ACTIVE);

  // R6
  run_order_chk: assert property (@(posedge clk) disable iff (!arst_n)
    (seq_phase == PH_RUN && $past(seq_phase) != PH_RUN) |-> $past(vec_fetch && phase_done));

  // R12
  clear_chk: assert property (@(posedge clk) disable iff (!arst_n)
    (cause_rd_clr && !seq_start) |=> rst_cause == SRC_NONE);
endmodule

bind rstseq_top rstseq_chk #(.DELAY_CYC(DELAY_CYC)) u_chk (
  .clk(clk), .arst_n(arst_n), .seq_phase(seq_phase), .core_rst_n(core_rst_n),
  .vec_fetch(vec_fetch), .pin_drv_low(pin_drv_low), .rst_cause(rst_cause),
  .lvd_above_rise(lvd_above_rise), .cause_rd_clr(cause_rd_clr),
  .seq_start(seq_start), .phase_done(phase_done)
);

// File: tb/tb_rstseq_top.sv
`timescale 1ns/1ps
module tb_rstseq_top;
  localparam int SYNC  = 2;
  localparam int MINP  = 4;
  localparam int LLONG = 16;
  localparam int LSHRT = 8;
  localparam int DLY   = 4096;

  localparam logic [1:0] P_ACT = 2'd0, P_DLY = 2'd1, P_FET = 2'd2, P_RUN = 2'd3;

  logic clk = 1'b0;
  logic arst_n, ext_n, lvd_below_fall, lvd_above_rise, wdg_expire, cause_rd_clr;
  logic core_rst_n, vec_fetch, pin_drv_low;
  logic [1:0] seq_phase, rst_cause;
  logic rst_pin_n;

  always #5 clk = ~clk;

  // Open-drain pin: external driver wired-AND with the block's own pull-down.
  assign rst_pin_n = ext_n & ~pin_drv_low;

  rstseq_top dut (
    .clk(clk), .arst_n(arst_n), .rst_pin_n(rst_pin_n),
    .lvd_below_fall(lvd_below_fall), .lvd_above_rise(lvd_above_rise),
    .wdg_expire(wdg_expire), .cause_rd_clr(cause_rd_clr),
    .core_rst_n(core_rst_n), .vec_fetch(vec_fetch), .seq_phase(seq_phase),
    .pin_drv_low(pin_drv_low), .rst_cause(rst_cause)
  );

  int unsigned cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0;
  int n_fail = 0;

  typedef struct {
    logic [1:0]  ph;
    int unsigned at;
    string       tag;
  } exp_t;
  exp_t sb[$];

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic push_active(input int unsigned a, input string tag);
    sb.push_back('{P_ACT, a, tag});
  endtask

  task automatic push_tail(input int unsigned d);
    sb.push_back('{P_DLY, d, "R4 active length"});
    sb.push_back('{P_FET, d + DLY, "R5 delay length"});
    sb.push_back('{P_RUN, d + DLY + 2, "R6 fetch length"});
  endtask

  task automatic push_seq(input int unsigned a, input int unsigned len, input string tag);
    push_active(a, tag);
    push_tail(a + len);
  endtask

  task automatic wait_phase(input logic [1:0] p);
    do @(negedge clk); while (seq_phase !== p);
  endtask

  // Monitor: every phase change must match the next expected item.
  logic [1:0] prev_ph = P_ACT;
  always @(negedge clk) begin
    if (arst_n === 1'b1 && seq_phase !== prev_ph) begin
      if (sb.size() == 0) begin
        check(1'b0, "R2 unexpected phase change", int'(seq_phase), int'(prev_ph));
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(seq_phase === e.ph, e.tag, int'(seq_phase), int'(e.ph));
        check(cyc == e.at, e.tag, int'(cyc), int'(e.at));
      end
      prev_ph = seq_phase;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog expired", int'(cyc), 0);
    summary();
    $finish;
  end

  initial begin
    int unsigned n, m, k;
    ext_n = 1'b1; wdg_expire = 1'b0; lvd_below_fall = 1'b0;
    lvd_above_rise = 1'b1; cause_rd_clr = 1'b0; arst_n = 1'b0;
    #2;
    check(seq_phase === P_ACT && core_rst_n === 1'b0, "R1 phase during arst", int'(seq_phase), 0);
    repeat (3) step();
    arst_n = 1'b1;
    push_tail(cyc + LLONG);
    @(negedge clk);
    check(seq_phase === P_ACT, "R1 phase after release", int'(seq_phase), 0);
    check(core_rst_n === 1'b0, "R1 core reset", int'(core_rst_n), 0);
    check(rst_cause === 2'b00, "R1 cause", int'(rst_cause), 0);
    check(pin_drv_low === 1'b0, "R1 pin", int'(pin_drv_low), 0);
    wait_phase(P_DLY);
    check(pin_drv_low === 1'b0, "R7 power-up pin", int'(pin_drv_low), 0);
    check(core_rst_n === 1'b0, "R5 core held", int'(core_rst_n), 0);
    wait_phase(P_FET);
    check(core_rst_n === 1'b1 && vec_fetch === 1'b1, "R6 fetch outputs",
          int'({core_rst_n, vec_fetch}), 3);
    wait_phase(P_RUN);

    // R3: pulse one clock too short
    step(); ext_n = 1'b0;
    repeat (MINP - 1) step();
    ext_n = 1'b1;
    repeat (12) step();
    check(seq_phase === P_RUN, "R3 short pulse phase", int'(seq_phase), 3);
    check(rst_cause === 2'b00, "R3 short pulse cause", int'(rst_cause), 0);

    // R2: qualified external pulse, with an ignored supply glitch in active (R10)
    step(); n = cyc; ext_n = 1'b0;
    push_seq(n + SYNC + MINP, LLONG, "R2 external entry");
    repeat (MINP) step();
    ext_n = 1'b1;
    wait_phase(P_ACT);
    step(); step();
    lvd_below_fall = 1'b1; lvd_above_rise = 1'b0;
    step();
    lvd_below_fall = 1'b0; lvd_above_rise = 1'b1;
    check(rst_cause === 2'b01, "R10 cause kept", int'(rst_cause), 1);
    check(pin_drv_low === 1'b0, "R7 external pin", int'(pin_drv_low), 0);
    wait_phase(P_RUN);

    // R2/R4: watchdog, short active length, pin driven
    step(); n = cyc; wdg_expire = 1'b1;
    push_seq(n + 1, LSHRT, "R2 watchdog entry");
    step(); wdg_expire = 1'b0;
    check(rst_cause === 2'b11, "R11 watchdog code", int'(rst_cause), 3);
    check(pin_drv_low === 1'b1, "R7 watchdog pin active", int'(pin_drv_low), 1);
    wait_phase(P_DLY);
    check(pin_drv_low === 1'b1, "R7 watchdog pin delay", int'(pin_drv_low), 1);
    wait_phase(P_FET);
    check(pin_drv_low === 1'b0, "R7 pin released", int'(pin_drv_low), 0);
    wait_phase(P_RUN);

    // R12: sticky value, then clear
    repeat (5) step();
    check(rst_cause === 2'b11, "R12 sticky", int'(rst_cause), 3);
    cause_rd_clr = 1'b1;
    step(); cause_rd_clr = 1'b0;
    check(rst_cause === 2'b00, "R12 cleared", int'(rst_cause), 0);

    // R12: clear and request together, request wins
    step(); n = cyc; cause_rd_clr = 1'b1; wdg_expire = 1'b1;
    push_seq(n + 1, LSHRT, "R12 request entry");
    step(); cause_rd_clr = 1'b0; wdg_expire = 1'b0;
    check(rst_cause === 2'b11, "R12 request wins", int'(rst_cause), 3);
    wait_phase(P_RUN);

    // R8: supply held low past the active length
    step(); n = cyc; lvd_below_fall = 1'b1; lvd_above_rise = 1'b0;
    push_active(n + 1, "R2 supply entry");
    repeat (30) step();
    check(seq_phase === P_ACT, "R8 held while low", int'(seq_phase), 0);
    check(pin_drv_low === 1'b1, "R7 supply pin", int'(pin_drv_low), 1);
    check(rst_cause === 2'b10, "R11 supply code", int'(rst_cause), 2);
    lvd_below_fall = 1'b0;
    step(); m = cyc; lvd_above_rise = 1'b1;
    push_tail(m + 1);
    wait_phase(P_RUN);

    // R9: restart in delay (supply) and in fetch (watchdog)
    step(); n = cyc; wdg_expire = 1'b1;
    push_seq(n + 1, LSHRT, "R2 watchdog entry");
    step(); wdg_expire = 1'b0;
    repeat (100) step();
    k = cyc; lvd_below_fall = 1'b1; lvd_above_rise = 1'b0;
    sb.delete();
    push_seq(k + 1, LLONG, "R9 restart from delay");
    step(); lvd_below_fall = 1'b0; lvd_above_rise = 1'b1;
    check(rst_cause === 2'b10, "R9 delay restart cause", int'(rst_cause), 2);
    wait_phase(P_FET);
    step(); k = cyc; wdg_expire = 1'b1;
    sb.delete();
    push_seq(k + 1, LSHRT, "R9 restart from fetch");
    step(); wdg_expire = 1'b0;
    check(rst_cause === 2'b11, "R9 fetch restart cause", int'(rst_cause), 3);
    wait_phase(P_RUN);

    // R11: supply and watchdog together
    step(); n = cyc; lvd_below_fall = 1'b1; lvd_above_rise = 1'b0; wdg_expire = 1'b1;
    push_seq(n + 1, LLONG, "R11 priority entry");
    step(); lvd_below_fall = 1'b0; lvd_above_rise = 1'b1; wdg_expire = 1'b0;
    check(rst_cause === 2'b10, "R11 supply beats watchdog", int'(rst_cause), 2);
    wait_phase(P_RUN);

    repeat (4) step();
    check(sb.size() == 0, "R2 all expected phases seen", sb.size(), 0);
    summary();
    $finish;
  end
endmodule